// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It produces an 8-bit status word for a serial port's register file. The upper nibble shows the present asserted state of each line. The lower nibble holds sticky flags that record a change on each line since the status word was last read. A read strobe clears the flags. While any flag is set, an interrupt request is raised for the port's interrupt logic.

Each pin passes through a two-flop synchronizer. In loopback mode the state nibble is taken from four local modem-control outputs instead of the pins. Change detection then runs on that source, so software can test the flag logic without any external wiring.

Top module: `modem_status_det`

## Requirements
- R1: Status bit 0 becomes 1 after any change, in either direction, of the clear-to-send line state.
- R2: Status bit 1 becomes 1 after any change of the data-set-ready line state.
- R3: Status bit 2 becomes 1 only when the ring pin goes from 0 to 1 (ring state bit 6 falls from 1 to 0). A ring pin falling from 1 to 0 leaves bit 2 at 0.
- R4: Status bit 3 becomes 1 after any change of the carrier-detect line state.
- R5: Outside loopback, bits 4, 5, 6 and 7 are the complements of the synchronized clear-to-send, data-set-ready, ring and carrier-detect pins.
- R6: A one-cycle `rd_i` strobe clears bits 3:0 at the next clock edge. Without a read, a set flag stays set.
- R7: A change detected at the same edge as a read leaves that line's flag at 1.
- R8: `irq_o` is 1 exactly when any of status bits 3:0 is 1.
- R9: With `loop_en_i` at 1, bits 4, 5, 6 and 7 equal `rts_i`, `dtr_i`, `out1_i` and `out2_i`. Pin activity is then ignored, and change flags follow the loopback source, including the transitions into and out of loopback.
- R10: After reset the status word is 0x00 and `irq_o` is 0. A pin change reaches the state bits on the second clock edge and the flag bits on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| dcd_ni | input | 1 | Carrier detect pin, active low |
| loop_en_i | input | 1 | Loopback enable from the modem-control register |
| rts_i | input | 1 | Request-to-send control bit (loopback source for bit 4) |
| dtr_i | input | 1 | Data-terminal-ready control bit (loopback source for bit 5) |
| out1_i | input | 1 | Auxiliary output 1 control bit (loopback source for bit 6) |
| out2_i | input | 1 | Auxiliary output 2 control bit (loopback source for bit 7) |
| rd_i | input | 1 | Status-word read strobe |
| status_o | output | 8 | State nibble [7:4], change flags [3:0] |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A table walk moves the pins one line at a time through assertion and release. The ring line is driven in both directions, which separates any-change detection from the trailing-edge-only rule. The final step releases three lines at once to show that the flags are independent. Directed tests then time a single pin change edge by edge to confirm synchronizer latency. One test lands a change on the same edge as a read, which shows whether the event is kept or the read wins. A loopback sequence shows that pins are ignored, that a ring-source fall is flagged and a rise is not, and that leaving loopback counts as a change.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_DCD = 3;

  typedef enum logic {DET_ANY = 1'b0, DET_FALL = 1'b1} det_mode_e;

  // ring flag only on state 1->0 (pin trailing edge)
  function automatic det_mode_e line_mode(int unsigned idx);
    return (idx == IDX_RI) ? DET_FALL : DET_ANY;
  endfunction
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msd_src_sel.sv
module msd_src_sel #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             loop_en_i,
  input  logic [WIDTH-1:0] pin_n_i,
  input  logic [WIDTH-1:0] loop_i,
  output logic [WIDTH-1:0] state_o
);
  always_comb state_o = loop_en_i ? loop_i : ~pin_n_i;
endmodule

// File: rtl/msd_flag_bank.sv
module msd_flag_bank
  import msd_pkg::*;
#(
  parameter int unsigned WIDTH = NUM_LINES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] state_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] prev_q, flag_q, chg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    if (line_mode(i) == DET_FALL) begin : g_fall
      assign chg[i] = prev_q[i] & ~state_i[i];
    end else begin : g_any
      assign chg[i] = prev_q[i] ^ state_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= state_i;
      // new event wins over a coincident read
      flag_q <= (flag_q & {WIDTH{~rd_i}}) | chg;
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/modem_status_det.sv
module modem_status_det
  import msd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       dcd_ni,
  input  logic       loop_en_i,
  input  logic       rts_i,
  input  logic       dtr_i,
  input  logic       out1_i,
  input  logic       out2_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [NUM_LINES-1:0] pin_n, pin_n_sync, loop_src, state, flags;

  assign pin_n    = {dcd_ni, ri_ni, dsr_ni, cts_ni};
  assign loop_src = {out2_i, out1_i, dtr_i, rts_i};

  msd_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_n), .q_o(pin_n_sync)
  );

  msd_src_sel #(.WIDTH(NUM_LINES)) u_sel (
    .loop_en_i(loop_en_i), .pin_n_i(pin_n_sync), .loop_i(loop_src), .state_o(state)
  );

  msd_flag_bank #(.WIDTH(NUM_LINES)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .rd_i(rd_i), .flags_o(flags)
  );

  assign status_o = {state, flags};
  assign irq_o    = |flags;
endmodule

// File: rtl/modem_status_det_chk.sv
module modem_status_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic [7:0] status_o,
  input logic       irq_o
);
  a_r8_irq_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o[3:0] != 4'h0));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $stable(status_o[7:4])) |=> status_o[3:0] == 4'h0);

  a_r1_cts_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o[4]) |=> status_o[0]);

  a_r3_ri_trailing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[6]) |=> status_o[2]);

  a_r7_event_beats_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !$stable(status_o[7])) |=> status_o[3]);
endmodule

bind modem_status_det modem_status_det_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/modem_status_det_tb.sv
module modem_status_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {pins {dcd,ri,dsr,cts} active low, expected status}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'b1110, 8'h11},  // R1 cts asserted, R5
    {4'b1100, 8'h32},  // R2 dsr asserted
    {4'b1000, 8'h70},  // R3 ri pin falls: no flag
    {4'b0000, 8'hF8},  // R4 dcd asserted
    {4'b0100, 8'hB4},  // R3 ri pin rises: flag
    {4'b1111, 8'h0B},  // R1 R2 R4 release together
    {4'b1111, 8'h00}   // no change
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic loop_en = 1'b0, rts = 1'b0, dtr = 1'b0, out1 = 1'b0, out2 = 1'b0, rd = 1'b0;
  logic [7:0] status;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n),
    .dcd_ni(dcd_n), .loop_en_i(loop_en), .rts_i(rts), .dtr_i(dtr), .out1_i(out1),
    .out2_i(out2), .rd_i(rd), .status_o(status), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_pins(logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset status", status, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    settle();
    chk("R10 idle after reset", status, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      set_pins(VEC[i][11:8]);
      settle();
      chk("R1-4 table status", status, VEC[i][7:0]);
      chk("R8 table irq", {7'b0, irq}, {7'b0, |VEC[i][3:0]});
      do_read();
      chk("R6 read clears", {4'h0, status[3:0]}, 8'h00);
      chk("R8 irq low after read", {7'b0, irq}, 8'h00);
    end

    // R10 latency: state on 2nd edge, flag on 3rd
    cts_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 one edge", status, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R10 two edges", status, 8'h10);
    @(posedge clk); @(negedge clk);
    chk("R10 three edges", status, 8'h11);
    settle();
    chk("R6 flag held", status, 8'h11);
    do_read();
    cts_n = 1'b1;
    settle();
    do_read();
    chk("R1 released", status, 8'h00);

    // R7 change coincident with read
    cts_n = 1'b0;
    rd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    chk("R7 event kept", status, 8'h11);
    do_read();
    cts_n = 1'b1;
    settle();
    do_read();
    chk("R7 restored", status, 8'h00);

    // R9 loopback
    loop_en = 1'b1; rts = 1'b1; out2 = 1'b1;
    settle();
    chk("R9 loop enter", status, 8'h99);
    do_read();
    cts_n = 1'b0;
    settle();
    chk("R9 pins ignored", status, 8'h90);
    out1 = 1'b1;
    settle();
    chk("R9 R3 ring source rise no flag", status, 8'hD0);
    out1 = 1'b0;
    settle();
    chk("R9 R3 ring source fall flags", status, 8'h94);
    do_read();
    loop_en = 1'b0;
    settle();
    chk("R9 loop exit", status, 8'h18);
    do_read();
    cts_n = 1'b1;
    settle();
    chk("R5 back to pins", status, 8'h01);
    do_read();
    chk("R6 final clear", status, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule